// File: doc/BRIEF.md
# Programmable Tone Timer Interrupt Unit

This unit provides the three tone-channel counters of a home-computer sound chip together with the interrupt source built on them. Each channel loads a period from two byte registers. It counts down once per base tick and flips a square-wave output every time its count wraps. A per-channel hold bit freezes the counter at its period and forces the square wave low. Software uses this bit both to park a channel and to restart it in phase.

A selector in the control register chooses what drives the interrupt. The choices are two free-running fixed-rate dividers (250 and 5000 ticks, which give 1 kHz and 50 Hz from a 250 kHz tick) or the raw wrap pulse of channel 0 or channel 1. Every selected event flips a status bit. When the interrupt is enabled, the event also sets a sticky request, which software clears by writing a one to a clear bit. The CPU reaches the unit through a byte write port. The base tick is a single-cycle clock enable.

Top module: `tone_timer_irq`

## Requirements
- R1: After a synchronous active-low reset, all periods are 0, the control register is 07h (every channel held, fixed 250-tick source), the interrupt enable is 0, and tone_out, irq_status, irq_pending and irq are all 0.
- R2: Channel n takes its period from the low byte at address A0h+2n and the high byte at A1h+2n, of which only the low PERIOD_W-8 bits are kept. With period P and hold released, the channel wraps once every P+1 ticks, and each wrap toggles tone_out[n].
- R3: Nothing in the counters, dividers, tone outputs or status changes on a cycle without tick.
- R4: While bit n of the control register (address A7h) is 1, tone_out[n] is 0 from the next cycle on and the counter stays at the period. After release, the first wrap comes on the (P+1)th tick.
- R5: Setting a hold bit in the middle of a count stops that channel at once, so it produces no further wraps or toggles.
- R6: Control bits 6:5 select the interrupt event: 00 fixed 250-tick divider, 01 fixed 5000-tick divider, 10 channel 0 wrap, 11 channel 1 wrap.
- R7: The fixed dividers run freely from the tick, independent of the hold bits, and produce exactly one event in every 250 or 5000 consecutive ticks respectively.
- R8: Each selected event toggles irq_status, whether or not the interrupt is enabled.
- R9: The enable is bit 0 written to address B4h. A selected event sets irq_pending only while enabled, and irq is irq_pending AND the enable.
- R10: Writing B4h with bit 1 set clears irq_pending, and an enabled event in the same cycle wins. A B4h write with bit 1 clear leaves irq_pending unchanged.
- R11: Writes to any address other than A0h–A5h, A7h and B4h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Base-rate clock enable, one cycle per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| tone_out | output | 3 | Square-wave outputs, bit n for channel n |
| irq_status | output | 1 | Flips on each selected interrupt event |
| irq_pending | output | 1 | Sticky interrupt request |
| irq | output | 1 | Interrupt line to the CPU |

## Verification
A counter that has drifted shows up first as a tone edge one or more ticks away from where the period predicts. With channel 0 or 1 selected, the same error shifts the irq_status flip by the same amount, so the bench compares every output on every clock and catches the fault within one period. A wrong hold behaviour shows as a tone bit that stays high, or as a first wrap that comes too early or too late after release. A wrong request latch shows as irq staying high after a clear, or rising while disabled, in the very cycle after the write or event.

// File: rtl/tti_pkg.sv
// Shared types and register addresses for the tone timer interrupt unit.
package tti_pkg;
    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_CH0  = 2'd2,
        SRC_CH1  = 2'd3
    } irq_src_e;

    localparam logic [7:0] ADDR_PER_BASE = 8'hA0;
    localparam logic [7:0] ADDR_CTRL     = 8'hA7;
    localparam logic [7:0] ADDR_IRQ      = 8'hB4;
    localparam logic [7:0] CTRL_RESET    = 8'h07;
    localparam int         NUM_CH        = 3;
endpackage

// File: rtl/tti_tone_chan.sv
// One tone channel: a down-counter reloaded from its period and a square-wave
// flip-flop that flips on every wrap. Assumes tick is a one-cycle enable.
// A held channel loads its period on every cycle and drives its output low.
module tti_tone_chan #(
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                hold,
    input  logic [PERIOD_W-1:0] period,
    output logic                tone,
    output logic                wrap
);
    logic [PERIOD_W-1:0] cnt_q;

    // Wrap pulse: the tick that finds a running counter at zero.
    assign wrap = tick && !hold && (cnt_q == '0);

    // Counter: preload while held, count down on tick, reload after zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= period;
        end else if (tick) begin
            if (cnt_q == '0) cnt_q <= period;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Output flip-flop: forced low while held, flipped on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     tone <= 1'b0;
        else if (hold)  tone <= 1'b0;
        else if (wrap)  tone <= ~tone;
    end

    a_r4_hold_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tone);
    a_r4_hold_keeps_period: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> cnt_q == $past(period));
    a_r3_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> ($stable(cnt_q) && $stable(tone)));
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    a_r2_reload_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == $past(period) && tone != $past(tone)));
endmodule

// File: rtl/tti_fixed_div.sv
// Free-running fixed divider: counts RELOAD..0 on tick and pulses on the tick
// that finds zero, giving one event every RELOAD+1 ticks.
module tti_fixed_div #(
    parameter int RELOAD = 249
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic evt
);
    localparam int W = $clog2(RELOAD + 1);

    logic [W-1:0] cnt_q;

    // Event pulse on the zero-state tick.
    assign evt = tick && (cnt_q == '0);

    // Divider counter with reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= W'(RELOAD);
        else if (evt)    cnt_q <= W'(RELOAD);
        else if (tick)   cnt_q <= cnt_q - 1'b1;
    end

    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> cnt_q == W'(RELOAD));
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(RELOAD));
    a_r3_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/tti_irq_ctrl.sv
// Interrupt source selection, status toggle and sticky request latch.
// Assumes all event inputs are one-cycle pulses; set wins over clear.
module tti_irq_ctrl
    import tti_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt_fast,
    input  logic     evt_slow,
    input  logic     wrap0,
    input  logic     wrap1,
    input  irq_src_e src,
    input  logic     enable,
    input  logic     clear,
    output logic     status,
    output logic     pending,
    output logic     irq
);
    logic evt;

    // Event mux driven by the source selector.
    always_comb begin
        unique case (src)
            SRC_FAST: evt = evt_fast;
            SRC_SLOW: evt = evt_slow;
            SRC_CH0:  evt = wrap0;
            default:  evt = wrap1;
        endcase
    end

    // Status bit flips on every selected event.
    always_ff @(posedge clk) begin
        if (!rst_n)   status <= 1'b0;
        else if (evt) status <= ~status;
    end

    // Sticky request: cleared by software, set by an enabled event.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending && !clear) || (evt && enable);
    end

    assign irq = pending && enable;

    a_r8_toggle_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status != $past(status));
    a_r8_steady_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(status));
    a_r9_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !pending) |=> !pending);
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(evt && enable)) |=> !pending);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && enable) |=> pending);
endmodule

// File: rtl/tone_timer_irq.sv
// Top of the tone timer interrupt unit: byte register file, three tone
// channels, two fixed dividers and the interrupt controller.
// Assumes PERIOD_W between 9 and 16; high period bytes keep PERIOD_W-8 bits.
module tone_timer_irq
    import tti_pkg::*;
#(
    parameter int PERIOD_W    = 12,
    parameter int FAST_RELOAD = 249,
    parameter int SLOW_RELOAD = 4999
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [2:0] tone_out,
    output logic       irq_status,
    output logic       irq_pending,
    output logic       irq
);
    localparam int HI_W = PERIOD_W - 8;

    logic [7:0]      per_lo_q [NUM_CH];
    logic [HI_W-1:0] per_hi_q [NUM_CH];
    logic [7:0]      ctrl_q;
    logic            irq_en_q;
    logic [NUM_CH-1:0] wrap;
    logic            evt_fast;
    logic            evt_slow;
    logic            irq_clear;

    // Register writes: period bytes, control byte and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                per_lo_q[i] <= '0;
                per_hi_q[i] <= '0;
            end
            ctrl_q   <= CTRL_RESET;
            irq_en_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_PER_BASE + 8'(2 * i))
                    per_lo_q[i] <= wr_data;
                if (wr_addr == ADDR_PER_BASE + 8'(2 * i + 1))
                    per_hi_q[i] <= wr_data[HI_W-1:0];
            end
            if (wr_addr == ADDR_CTRL) ctrl_q   <= wr_data;
            if (wr_addr == ADDR_IRQ)  irq_en_q <= wr_data[0];
        end
    end

    // Clear strobe for the sticky request.
    assign irq_clear = wr_en && (wr_addr == ADDR_IRQ) && wr_data[1];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        tti_tone_chan #(.PERIOD_W(PERIOD_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .hold   (ctrl_q[g]),
            .period ({per_hi_q[g], per_lo_q[g]}),
            .tone   (tone_out[g]),
            .wrap   (wrap[g])
        );
    end

    tti_fixed_div #(.RELOAD(FAST_RELOAD)) u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .evt   (evt_fast)
    );

    tti_fixed_div #(.RELOAD(SLOW_RELOAD)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .evt   (evt_slow)
    );

    tti_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_fast (evt_fast),
        .evt_slow (evt_slow),
        .wrap0    (wrap[0]),
        .wrap1    (wrap[1]),
        .src      (irq_src_e'(ctrl_q[6:5])),
        .enable   (irq_en_q),
        .clear    (irq_clear),
        .status   (irq_status),
        .pending  (irq_pending),
        .irq      (irq)
    );

    a_r11_ctrl_only_by_a7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_CTRL) |=> $stable(ctrl_q));
    a_r11_enable_only_by_b4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_IRQ) |=> $stable(irq_en_q));
    a_r5_held_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wrap & ctrl_q[NUM_CH-1:0]) == 0);
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_pending && irq_en_q));
endmodule

// File: tb/tb_tone_timer_irq.sv
// Bench: behavioural reference model compared on every clock, plus directed
// edge counts derived from the requirements.
module tb_tone_timer_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] tone_out;
    logic       irq_status, irq_pending, irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit chk_on = 0;
    string cur_req = "R1";

    // Edge counters fed by the monitor.
    int tog_t[3];
    int tog_st;
    logic [2:0] prev_t;
    logic prev_st;

    // Reference model state.
    int m_lo[3], m_hi[3], m_cnt[3], m_ff[3];
    int m_fast, m_slow, m_ctrl;
    bit m_en, m_latch, m_status;

    tone_timer_irq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tone_out(tone_out),
        .irq_status(irq_status), .irq_pending(irq_pending), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, one step per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_lo[i] = 0; m_hi[i] = 0; m_cnt[i] = 0; m_ff[i] = 0;
            end
            m_ctrl = 8'h07; m_en = 0; m_latch = 0; m_status = 0;
            m_fast = 249; m_slow = 4999;
        end else begin
            bit uf[3];
            bit ef, es, ev, clr;
            for (int i = 0; i < 3; i++) begin
                int per;
                bit hold;
                per  = m_hi[i] * 256 + m_lo[i];
                hold = ((m_ctrl >> i) & 1) != 0;
                uf[i] = tick && !hold && m_cnt[i] == 0;
                if (hold) begin
                    m_cnt[i] = per; m_ff[i] = 0;
                end else if (tick) begin
                    if (m_cnt[i] == 0) begin
                        m_cnt[i] = per; m_ff[i] = 1 - m_ff[i];
                    end else m_cnt[i] = m_cnt[i] - 1;
                end
            end
            ef = tick && m_fast == 0;
            es = tick && m_slow == 0;
            if (tick) begin
                m_fast = (m_fast == 0) ? 249 : m_fast - 1;
                m_slow = (m_slow == 0) ? 4999 : m_slow - 1;
            end
            case ((m_ctrl >> 5) & 3)
                0: ev = ef;
                1: ev = es;
                2: ev = uf[0];
                default: ev = uf[1];
            endcase
            clr = wr_en && wr_addr == 8'hB4 && wr_data[1];
            if (ev) m_status = !m_status;
            m_latch = (m_latch && !clr) || (ev && m_en);
            if (wr_en) begin
                for (int i = 0; i < 3; i++) begin
                    if (wr_addr == 8'(8'hA0 + 2 * i))     m_lo[i] = wr_data;
                    if (wr_addr == 8'(8'hA0 + 2 * i + 1)) m_hi[i] = wr_data & 8'h0F;
                end
                if (wr_addr == 8'hA7) m_ctrl = wr_data;
                if (wr_addr == 8'hB4) m_en = wr_data[0];
            end
        end
    end

    // Monitor: compare outputs and count edges between clock edges.
    always @(posedge clk) begin
        #2;
        cycles++;
        if (chk_on) begin
            int exp_t;
            exp_t = m_ff[0] + 2 * m_ff[1] + 4 * m_ff[2];
            check({cur_req, " tone_out vs model"}, int'(tone_out), exp_t);
            check({cur_req, " irq_status vs model"}, int'(irq_status), int'(m_status));
            check({cur_req, " irq_pending vs model"}, int'(irq_pending), int'(m_latch));
            check({cur_req, " irq vs model"}, int'(irq), int'(m_latch && m_en));
            for (int i = 0; i < 3; i++)
                if (tone_out[i] != prev_t[i]) tog_t[i]++;
            if (irq_status != prev_st) tog_st++;
        end
        prev_t  = tone_out;
        prev_st = irq_status;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 3; i++) tog_t[i] = 0;
        tog_st = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 tone_out after reset", int'(tone_out), 0);
        check("R1 irq_status after reset", int'(irq_status), 0);
        check("R1 irq_pending after reset", int'(irq_pending), 0);
        check("R1 irq after reset", int'(irq), 0);

        // R2: ch0 period 3, high byte upper nibble must be dropped.
        cur_req = "R2";
        tick = 1'b1;
        wr(8'hA0, 8'h03);
        wr(8'hA1, 8'hF0);
        wr(8'hA7, 8'h06);
        clear_counts();
        repeat (40) @(negedge clk);
        check("R2 ch0 toggles in 40 ticks, period 3", tog_t[0], 10);

        // R3: no tick, nothing moves.
        cur_req = "R3";
        tick = 1'b0;
        clear_counts();
        repeat (50) @(negedge clk);
        check("R3 ch0 toggles without tick", tog_t[0], 0);
        check("R3 status toggles without tick", tog_st, 0);

        // R6: channel 0 wrap as the interrupt source.
        cur_req = "R6";
        wr(8'hA7, 8'h46);
        tick = 1'b1;
        clear_counts();
        repeat (40) @(negedge clk);
        check("R6 status toggles from ch0 source", tog_st, 10);

        // R8/R9: ch1 period 5, source ch1, enabled.
        cur_req = "R9";
        tick = 1'b0;
        wr(8'hA2, 8'h05);
        wr(8'hB4, 8'h01);
        wr(8'hA7, 8'h65);
        tick = 1'b1;
        clear_counts();
        repeat (60) @(negedge clk);
        tick = 1'b0;
        check("R8 status toggles from ch1 source", tog_st, 10);
        check("R2 ch1 toggles in 60 ticks, period 5", tog_t[1], 10);
        @(negedge clk);
        check("R9 irq raised when enabled", int'(irq), 1);

        cur_req = "R10";
        wr(8'hB4, 8'h01);
        check("R10 write without clear bit keeps irq", int'(irq), 1);
        wr(8'hB4, 8'h03);
        check("R10 clear drops pending", int'(irq_pending), 0);
        check("R10 clear drops irq", int'(irq), 0);

        cur_req = "R9";
        wr(8'hB4, 8'h00);
        tick = 1'b1;
        clear_counts();
        repeat (60) @(negedge clk);
        check("R8 status toggles while disabled", tog_st, 10);
        check("R9 pending stays low while disabled", int'(irq_pending), 0);

        // R11: writes to unused addresses change nothing.
        cur_req = "R11";
        wr(8'hA6, 8'hFF);
        wr(8'hB5, 8'hFF);
        wr(8'hA8, 8'hFF);
        wr(8'h00, 8'hFF);
        clear_counts();
        repeat (60) @(negedge clk);
        check("R11 ch1 still runs after stray writes", tog_t[1], 10);
        check("R11 irq still disabled after stray writes", int'(irq), 0);

        // R5: hold in mid count, then R4 restart phase.
        cur_req = "R5";
        repeat (2) @(negedge clk);
        wr(8'hA7, 8'h67);
        @(negedge clk);
        check("R5 tones low once held", int'(tone_out), 0);
        clear_counts();
        repeat (30) @(negedge clk);
        check("R5 no ch1 toggles while held", tog_t[1], 0);
        check("R5 no status toggles while held", tog_st, 0);

        cur_req = "R4";
        wr(8'hA7, 8'h65);
        repeat (5) @(negedge clk);
        check("R4 ch1 low before 6th tick", int'(tone_out[1]), 0);
        @(negedge clk);
        check("R4 ch1 high on 6th tick", int'(tone_out[1]), 1);

        // R2: high byte used for ch2, period 0x102.
        cur_req = "R2";
        wr(8'hA4, 8'h02);
        wr(8'hA5, 8'hF1);
        wr(8'hA7, 8'h03);
        clear_counts();
        repeat (259 * 4) @(negedge clk);
        check("R2 ch2 toggles, period 258", tog_t[2], 4);

        // R7: fixed dividers.
        cur_req = "R7";
        wr(8'hA7, 8'h07);
        clear_counts();
        repeat (2500) @(negedge clk);
        check("R7 fast divider events in 2500 ticks", tog_st, 10);
        wr(8'hA7, 8'h27);
        clear_counts();
        repeat (10000) @(negedge clk);
        check("R7 slow divider events in 10000 ticks", tog_st, 2);

        // R10: enabled clears racing with frequent events, model-checked.
        cur_req = "R10";
        wr(8'hA0, 8'h00);
        wr(8'hB4, 8'h01);
        wr(8'hA7, 8'h46);
        for (int k = 0; k < 20; k++) wr(8'hB4, 8'h03);
        check("R10 same-cycle event keeps pending", int'(irq_pending), 1);

        chk_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule